// File: doc/BRIEF.md
# Strobe-Framed Serial Access Master

This block is the host side of a three-wire serial link with a separate active-low framing strobe. A single request carries an 8-bit register address, a direction flag and, for writes, a 32-bit word. The engine turns that request into a serial frame: a clock line (`sck`), a data-out line (`mosi`) and a strobe (`strobe_n`). For reads it then collects a 32-bit reply from the data-in line (`miso`). A programmable count of system clocks sets the serial clock speed.

A frame always closes with one command clock taken while the strobe is low. The level of `mosi` during that clock tells the target the direction: high means write, low means read. A read sends the address, gives the command clock, releases the strobe and then clocks in 32 reply bits. A write sends the data word first, then the address, then the command clock. Every field goes out most significant bit first.

The controller is a single state machine with these states:
- `ST_IDLE`: waiting for a request.
- `ST_WDATA`: shifting out write data.
- `ST_ADDR`: shifting out the address.
- `ST_CMD`: the command clock under the strobe.
- `ST_TAIL`: a half period with the strobe still low and `sck` low.
- `ST_RDATA`: shifting in read data.
- `ST_DONE`: the completion cycle.

Its transitions are:
- `ST_IDLE`→`ST_WDATA` on accepting a write.
- `ST_IDLE`→`ST_ADDR` on accepting a read.
- `ST_WDATA`→`ST_ADDR` after the 32nd data bit.
- `ST_ADDR`→`ST_CMD` after the 8th address bit.
- `ST_CMD`→`ST_TAIL` after the command clock falls.
- `ST_TAIL`→`ST_RDATA` (read) or `ST_TAIL`→`ST_DONE` (write) at the end of the tail half period.
- `ST_RDATA`→`ST_DONE` after the 32nd reply bit.
- `ST_DONE`→`ST_IDLE` unconditionally.

Top module: `ssm_strobe_master`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, `sck` is 0, `strobe_n` is 1 and `done` is 0.
- R2: A read (`req_write`=0) shifts out the 8 address bits MSB first, one `sck` pulse per bit. It then gives exactly one further `sck` pulse with `strobe_n` low and `mosi` 0.
- R3: A write (`req_write`=1) shifts out the 32 data bits MSB first, then the 8 address bits MSB first. It then gives one `sck` pulse with `strobe_n` low and `mosi` 1.
- R4: After the strobe is released, a read clocks in 32 bits from `miso`, MSB first. Each bit is taken from the two-flop-synchronized `miso` at the last system clock of the `sck` high phase and shifted into the LSB. The word appears on `rdata` in the cycle `done` is high. A correct read requires a half period of at least 2.
- R5: `strobe_n` falls together with the start of the command clock's low half. It covers exactly one `sck` rising edge and rises one half period after that clock's falling edge, so it stays low for three half periods.
- R6: Each `sck` low phase and high phase lasts H system clocks. H is `half_div`, sampled when the request is accepted; later changes have no effect on that frame. A frame keeps `req_ready` low for 83·H+1 cycles, counting the `done` cycle.
- R7: A request is accepted in a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle through the `done` cycle. `done` is a one-cycle pulse and is followed by `req_ready` high.
- R8: A `half_div` of 0 is treated as 1.
- R9: `mosi` changes only while `sck` is low; it is stable on every cycle in which `sck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | 8 | Serial half period in system clocks (0 acts as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, can accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Target register address |
| req_wdata | input | 32 | Word to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Word read, valid with `done` |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the target |
| strobe_n | output | 1 | Active-low frame strobe, idles high |
| miso | input | 1 | Serial data from the target |

## Verification
Each kind of fault shows up at the ports in a different way and at a different time:
- A wrong bit counter changes the number of `sck` rises the target sees before the strobe. It also changes the total busy time, so it appears at the strobe edge or, at the latest, at `done`.
- A wrong transmit register shows up at the target as a wrong address or data value within that frame.
- A wrong phase or a timer reload error stretches or shrinks a half period. This shifts the busy count and the strobe-low window, which the bench measures for each frame.
- A fault in the receive path surfaces only at `done`, as a wrong `rdata` compared against a known target pattern.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WDATA,
        ST_ADDR,
        ST_CMD,
        ST_TAIL,
        ST_RDATA,
        ST_DONE
    } ssm_state_e;

endpackage

// File: rtl/ssm_halfper_timer.sv
module ssm_halfper_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_lat;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    // a zero divide request behaves as one
    assign div_eff = (div_in == '0) ? DIV_W'(1) : div_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_lat <= DIV_W'(1);
            cnt     <= '0;
        end else if (start) begin
            div_lat <= div_eff;
            cnt     <= div_eff - DIV_W'(1);
        end else if (run) begin
            if (cnt == '0) cnt <= div_lat - DIV_W'(1);
            else           cnt <= cnt - DIV_W'(1);
        end
    end

    assign tick = run && (cnt == '0);
endmodule

// File: rtl/ssm_sync.sv
module ssm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= d;
                else             chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ssm_frame_fsm.sv
module ssm_frame_fsm
    import ssm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              tick,
    input  logic              miso_s,
    output logic              req_ready,
    output logic              tmr_start,
    output logic              tmr_run,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sck,
    output logic              mosi,
    output logic              strobe_n
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int PAD_W = DATA_W - ADDR_W;

    ssm_state_e        state, state_nxt;
    logic              phase_hi;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [ADDR_W-1:0] addr_hold;
    logic              wr_flag;

    logic accept;
    logic shifting;
    logic hi_end;
    logic last_data;
    logic last_addr;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign shifting  = (state == ST_WDATA) || (state == ST_ADDR) ||
                       (state == ST_CMD)   || (state == ST_RDATA);
    assign hi_end    = tick && phase_hi;
    assign last_data = (bit_cnt == CNT_W'(DATA_W-1));
    assign last_addr = (bit_cnt == CNT_W'(ADDR_W-1));

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nxt = req_write ? ST_WDATA : ST_ADDR;
            ST_WDATA: if (hi_end && last_data) state_nxt = ST_ADDR;
            ST_ADDR:  if (hi_end && last_addr) state_nxt = ST_CMD;
            ST_CMD:   if (hi_end) state_nxt = ST_TAIL;
            ST_TAIL:  if (tick) state_nxt = wr_flag ? ST_DONE : ST_RDATA;
            ST_RDATA: if (hi_end && last_data) state_nxt = ST_DONE;
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // shift path, phase and bit counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_hi  <= 1'b0;
            bit_cnt   <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            addr_hold <= '0;
            wr_flag   <= 1'b0;
        end else if (accept) begin
            wr_flag   <= req_write;
            addr_hold <= req_addr;
            tx_sr     <= req_write ? req_wdata : {req_addr, {PAD_W{1'b0}}};
            rx_sr     <= '0;
            phase_hi  <= 1'b0;
            bit_cnt   <= '0;
        end else if (shifting && tick) begin
            phase_hi <= ~phase_hi;
            if (phase_hi) begin
                bit_cnt <= (state_nxt != state) ? '0 : bit_cnt + CNT_W'(1);
                if (state == ST_WDATA && state_nxt == ST_ADDR)
                    tx_sr <= {addr_hold, {PAD_W{1'b0}}};
                else
                    tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                if (state == ST_RDATA)
                    rx_sr <= {rx_sr[DATA_W-2:0], miso_s};
            end
        end
    end

    // output decode
    always_comb begin
        req_ready = (state == ST_IDLE);
        done      = (state == ST_DONE);
        tmr_start = accept;
        tmr_run   = (state != ST_IDLE) && (state != ST_DONE);
        sck       = shifting && phase_hi;
        strobe_n  = !((state == ST_CMD) || (state == ST_TAIL));
        unique case (state)
            ST_WDATA, ST_ADDR: mosi = tx_sr[DATA_W-1];
            ST_CMD:            mosi = wr_flag;
            default:           mosi = 1'b0;
        endcase
    end

    assign rdata = rx_sr;
endmodule

// File: rtl/ssm_strobe_master.sv
module ssm_strobe_master #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sck,
    output logic              mosi,
    output logic              strobe_n,
    input  logic              miso
);
    logic tick;
    logic tmr_start;
    logic tmr_run;
    logic miso_s;

    ssm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (miso),
        .q     (miso_s)
    );

    ssm_halfper_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .run    (tmr_run),
        .div_in (half_div),
        .tick   (tick)
    );

    ssm_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .tick      (tick),
        .miso_s    (miso_s),
        .req_ready (req_ready),
        .tmr_start (tmr_start),
        .tmr_run   (tmr_run),
        .done      (done),
        .rdata     (rdata),
        .sck       (sck),
        .mosi      (mosi),
        .strobe_n  (strobe_n)
    );
endmodule

// File: rtl/ssm_strobe_master_chk.sv
module ssm_strobe_master_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic sck,
    input logic mosi,
    input logic strobe_n
);
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!sck && strobe_n && !done)); // R1

    AST_STROBE_FALL_LOW_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n) |-> !sck); // R5

    AST_STROBE_RISE_LOW_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n) |-> (!sck && !$past(sck))); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R7

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R7

    AST_MOSI_HELD_HIGH_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi)); // R9
endmodule

bind ssm_strobe_master ssm_strobe_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .sck       (sck),
    .mosi      (mosi),
    .strobe_n  (strobe_n)
);

// File: tb/ssm_strobe_master_test.sv
`timescale 1ns/1ps
module ssm_strobe_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  half_div = 8'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rdata;
    logic        sck;
    logic        mosi;
    logic        strobe_n;
    logic        miso = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ssm_strobe_master uut (
        .clk(clk), .rst_n(rst_n), .half_div(half_div),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .sck(sck), .mosi(mosi), .strobe_n(strobe_n), .miso(miso)
    );

    typedef struct {
        bit          wr;
        logic [7:0]  addr;
        logic [31:0] data;
        int          h;
    } exp_t;

    typedef struct {
        bit          cmd;
        logic [7:0]  addr;
        logic [31:0] data;
        int          nclk;
    } frm_t;

    exp_t exp_q[$];
    frm_t frm_q[$];

    function automatic logic [31:0] tgt_val(logic [7:0] a);
        return {a, ~a, a ^ 8'h5A, 8'hC3};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // target model: captures shifted bits, answers reads
    logic [63:0] hist = '0;
    int          pre_cnt = 0;
    bit          rd_act = 0;
    int          rd_left = 0;
    logic [31:0] rd_word = '0;

    always @(posedge sck) begin
        if (!strobe_n) begin
            frm_t f;
            f.cmd  = mosi;
            f.addr = hist[7:0];
            f.data = hist[39:8];
            f.nclk = pre_cnt;
            frm_q.push_back(f);
            pre_cnt = 0;
            if (!mosi) begin
                rd_act  = 1;
                rd_word = tgt_val(hist[7:0]);
                rd_left = 32;
            end
        end else if (!rd_act) begin
            hist = {hist[62:0], mosi};
            pre_cnt++;
        end
    end

    always @(negedge sck) begin
        if (rd_act) begin
            if (rd_left > 0) begin
                miso = rd_word[31];
                rd_word = rd_word << 1;
                rd_left--;
            end else begin
                rd_act = 0;
                miso = 1'b0;
            end
        end
    end

    // monitor / scoreboard
    int busy_cnt = 0;
    int stb_cnt  = 0;
    bit done_prev = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done_prev) begin
                chk(!done && req_ready, "R7", "done pulse width / ready return",
                    {done, req_ready}, 2'b01);
            end
            done_prev = done;
            if (req_ready) begin
                chk(!sck && strobe_n && !done, "R1", "idle lines",
                    {sck, strobe_n, done}, 3'b010);
            end else begin
                busy_cnt++;
            end
            if (!strobe_n) stb_cnt++;
            if (done) begin
                if (exp_q.size() == 0 || frm_q.size() == 0) begin
                    chk(0, "R7", "done without pending request/frame", exp_q.size(), frm_q.size());
                end else begin
                    exp_t e;
                    frm_t f;
                    e = exp_q.pop_front();
                    f = frm_q.pop_front();
                    chk(f.cmd == e.wr, e.wr ? "R3" : "R2", "command bit", f.cmd, e.wr);
                    chk(f.addr == e.addr, e.wr ? "R3" : "R2", "address", f.addr, e.addr);
                    if (e.wr) begin
                        chk(f.data == e.data, "R3", "write data", f.data, e.data);
                        chk(f.nclk == 40, "R3", "clocks before strobe", f.nclk, 40);
                    end else begin
                        chk(f.nclk == 8, "R2", "clocks before strobe", f.nclk, 8);
                        chk(rdata == tgt_val(e.addr), "R4", "read data", rdata, tgt_val(e.addr));
                    end
                    chk(busy_cnt == 83*e.h + 1, "R6", "busy length", busy_cnt, 83*e.h + 1);
                    chk(stb_cnt == 3*e.h, "R5", "strobe low length", stb_cnt, 3*e.h);
                end
                busy_cnt = 0;
                stb_cnt  = 0;
            end
        end
    end

    // driver
    task automatic issue(bit wr, logic [7:0] a, logic [31:0] d, logic [7:0] div);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.wr = wr; e.addr = a; e.data = d;
        e.h  = (div == 0) ? 1 : int'(div);   // R8: zero acts as one
        exp_q.push_back(e);
        half_div  = div;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~d;
        half_div  = div + 8'd3;             // R6: must not affect this frame
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!sck && strobe_n && !done && req_ready, "R1", "reset state",
            {sck, strobe_n, done, req_ready}, 4'b0101);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        issue(1'b1, 8'h80, 32'h0000_0001, 8'd1);   // R3
        issue(1'b1, 8'h02, 32'hA5A5_0F0F, 8'd0);   // R8
        issue(1'b0, 8'hFF, 32'h0, 8'd2);           // R2 R4
        issue(1'b0, 8'h00, 32'h0, 8'd3);           // R4
        issue(1'b0, 8'h08, 32'h0, 8'd5);           // R4 R5
        issue(1'b1, 8'h00, 32'h8000_0001, 8'd4);   // R3 R6
        issue(1'b0, 8'h80, 32'h0, 8'd2);           // R4
        issue(1'b1, 8'hFF, 32'hFFFF_FFFF, 8'd2);   // R3
        @(negedge clk);
        while (!req_ready || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(frm_q.size() == 0, "R7", "extra frames", frm_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule